// File: doc/BRIEF.md
# Interval Timer with Oscillator Stabilization Wait

This block is a free-running interval timer that runs on the system oscillator clock. A divider selects one of four power-of-two taps. The selected tick advances a small up-counter. Each wrap of that counter from its all-ones value back to zero raises an interrupt request flag. Software programs the tap through a 3-bit mode code. Only four code values are legal, and any other value written is discarded.

The same write can also carry a restart request. A restart clears the divider, the counter and the request flag, so a full interval follows. The counter value and the mode code can be read back at any time. The restart bit always reads as zero.

The counter also measures the oscillator settling wait in two cases: after reset, and after a pulse on the stop-release input. A ready output stays low during that wait and goes high on the first wrap that follows. Software clears the request flag with a one-cycle pulse.

Top module: `bt_interval_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, the mode readback is 4'b0011, the counter is 0, the request flag is 0 and ready is 0.
- R2: The mode code in wr_data[2:0] selects the tap. Code 000 uses TAP_A, 011 uses TAP_B, 101 uses TAP_C and 111 uses TAP_D. The request flag rises exactly 2^(TAP+CNT_W) clocks after the divider and counter are cleared. With the default parameters this gives 2^20, 2^17, 2^15 and 2^13 clocks.
- R3: A write of code 001, 010, 100 or 110 leaves the stored mode unchanged. mode_rd[2:0] still shows the previous code, and the interval still follows that code.
- R4: A write with wr_data[3]=1 clears the counter, the divider and the request flag at that clock edge. mode_rd[3] always reads 0. The next rise of the flag comes one full interval later.
- R5: While the timer runs, the request flag is set again at every interval, including the intervals after the first.
- R6: Once set, the request flag stays at 1 until irq_clr or a restart.
- R7: A one-cycle pulse on irq_clr clears the request flag. A wrap in the same cycle takes priority and sets the flag.
- R8: After reset, ready rises exactly one code-011 interval (2^(TAP_B+CNT_W) clocks) after reset is released.
- R9: A stop_rel pulse clears the divider and the counter and drives ready low. It leaves the request flag unchanged. Ready returns high one interval of the current mode later.
- R10: cnt_o advances by one every 2^TAP clocks of the selected tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for the mode register |
| wr_data | input | 4 | Bits [2:0]: mode code. Bit 3: restart |
| mode_rd | output | 4 | Stored mode code, with bit 3 reading 0 |
| cnt_o | output | CNT_W | Current counter value |
| irq_o | output | 1 | Interval request flag |
| irq_clr | input | 1 | One-cycle software clear of the request flag |
| stop_rel | input | 1 | One-cycle pulse on release from stop mode |
| ready_o | output | 1 | High once the stabilization wait has ended |

## Verification
The bench builds the timer with CNT_W=4 and taps 6, 3, 2 and 1. The four intervals are then 1024, 128, 64 and 32 clocks. At these lengths every legal code can be timed edge-exact to the wrap, including the cycle just before it. The bench can also reach several wraps in a row, the reset settling wait and a stop-release wait in a short run. The smaller counter width still keeps the tap selection, the illegal-code filtering and the clear priorities the same as in the default build.

// File: rtl/bt_pkg.sv
// Package: shared mode-code constants and decode helpers for the interval timer.
// Assumes a 3-bit mode code where only four values are legal.
package bt_pkg;

    localparam logic [2:0] MODE_SLOWEST = 3'b000;
    localparam logic [2:0] MODE_SLOW    = 3'b011;
    localparam logic [2:0] MODE_FAST    = 3'b101;
    localparam logic [2:0] MODE_FASTEST = 3'b111;
    localparam logic [2:0] MODE_RESET   = MODE_SLOW;

    // Is the code one of the four accepted tap selections?
    function automatic logic mode_legal(input logic [2:0] code);
        return (code == MODE_SLOWEST) || (code == MODE_SLOW) ||
               (code == MODE_FAST)    || (code == MODE_FASTEST);
    endfunction

    // Map a legal code onto a dense tap index 0..3 (slowest to fastest).
    function automatic logic [1:0] mode_index(input logic [2:0] code);
        logic [1:0] idx;
        case (code)
            MODE_SLOWEST: idx = 2'd0;
            MODE_SLOW:    idx = 2'd1;
            MODE_FAST:    idx = 2'd2;
            default:      idx = 2'd3;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/bt_mode_reg.sv
// Mode register: stores the 3-bit tap code and drops writes of illegal codes.
// Assumes wr_en is a one-cycle strobe; the restart bit is handled by the parent.
module bt_mode_reg
    import bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_code,
    output logic [2:0] mode_q,
    output logic [1:0] tap_sel
);

    logic code_ok;

    // Legality check of the incoming code.
    always_comb code_ok = mode_legal(wr_code);

    // Store legal codes; reset to the slow stabilization code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_RESET;
        else if (wr_en && code_ok)
            mode_q <= wr_code;
    end

    // Dense tap index for the prescaler.
    always_comb tap_sel = mode_index(mode_q);

    AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !code_ok) |=> $stable(mode_q)) else $error("illegal code changed mode"); // R3

    AST_MODE_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mode_legal(mode_q)) else $error("stored mode is illegal"); // R3

endmodule

// File: rtl/bt_prescaler.sv
// Prescaler: free-running binary divider that gives a one-cycle tick every
// 2^TAP clocks for the selected tap. Assumes each TAP is at least 1 and at most PRE_W.
module bt_prescaler #(
    parameter int TAP_A = 12,
    parameter int TAP_B = 9,
    parameter int TAP_C = 7,
    parameter int TAP_D = 5,
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] tap_sel,
    output logic       tick
);

    localparam int NUM_TAPS = 4;

    logic [PRE_W-1:0]    div_q;
    logic [NUM_TAPS-1:0] tap_hit;

    // Constant lookup of the tap exponent for index i.
    function automatic int tap_of(input int i);
        case (i)
            0:       return TAP_A;
            1:       return TAP_B;
            2:       return TAP_C;
            default: return TAP_D;
        endcase
    endfunction

    // Divider advance, cleared by restart or stop release.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // One terminal-count detector per tap.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign tap_hit[g] = &div_q[tap_of(g)-1:0];
    end

    // Pick the tick of the selected tap.
    always_comb tick = tap_hit[tap_sel];

    AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick) else $error("tick right after clear"); // R4

endmodule

// File: rtl/bt_counter.sv
// Interval counter: counts prescaler ticks and flags the all-ones to zero wrap.
// Assumes tick is a one-cycle pulse; clr takes priority over tick.
module bt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Count ticks; wrap naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Wrap event, suppressed when a clear lands in the same cycle.
    always_comb ovf_o = tick && (cnt_q == CNT_MAX) && !clr;

    assign cnt_o = cnt_q;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)) else $error("counter not cleared"); // R4

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt_q)) else $error("counter moved without tick"); // R10

    AST_OVF_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_q == '0)) else $error("no wrap after overflow"); // R2

endmodule

// File: rtl/bt_interval_timer.sv
// Interval timer top: mode register, prescaler and counter, plus the request
// flag and the stabilization-ready flag. Assumes wr_en, irq_clr and stop_rel
// are one-cycle pulses synchronous to clk.
module bt_interval_timer #(
    parameter int CNT_W = 8,
    parameter int TAP_A = 12,
    parameter int TAP_B = 9,
    parameter int TAP_C = 7,
    parameter int TAP_D = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_data,
    output logic [3:0]       mode_rd,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    input  logic             irq_clr,
    input  logic             stop_rel,
    output logic             ready_o
);

    localparam int MAX_AB = (TAP_A > TAP_B) ? TAP_A : TAP_B;
    localparam int MAX_CD = (TAP_C > TAP_D) ? TAP_C : TAP_D;
    localparam int PRE_W  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;

    logic [2:0] mode_q;
    logic [1:0] tap_sel;
    logic       restart;
    logic       clr;
    logic       tick;
    logic       ovf;
    logic       irq_q;
    logic       ready_q;

    // Restart request and the common divider/counter clear.
    always_comb begin
        restart = wr_en && wr_data[3];
        clr     = restart || stop_rel;
    end

    bt_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_code (wr_data[2:0]),
        .mode_q  (mode_q),
        .tap_sel (tap_sel)
    );

    bt_prescaler #(
        .TAP_A (TAP_A),
        .TAP_B (TAP_B),
        .TAP_C (TAP_C),
        .TAP_D (TAP_D),
        .PRE_W (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .tap_sel (tap_sel),
        .tick    (tick)
    );

    bt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (tick),
        .cnt_o (cnt_o),
        .ovf_o (ovf)
    );

    // Request flag: restart clears, a wrap sets, the software pulse clears.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            irq_q <= 1'b0;
        else if (ovf)
            irq_q <= 1'b1;
        else if (irq_clr)
            irq_q <= 1'b0;
    end

    // Ready flag: low through each settling wait, high from the first wrap after it.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_rel)
            ready_q <= 1'b0;
        else if (ovf)
            ready_q <= 1'b1;
    end

    assign mode_rd = {1'b0, mode_q};
    assign irq_o   = irq_q;
    assign ready_o = ready_q;

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!irq_o && cnt_o == '0)) else $error("restart did not clear"); // R4

    AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> irq_o) else $error("wrap did not raise request"); // R5

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr && !restart) |=> irq_o) else $error("request dropped"); // R6

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !ovf) |=> !irq_o) else $error("clear ignored"); // R7

    AST_READY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && ovf && !stop_rel) |=> ready_o) else $error("ready did not rise"); // R8

    AST_STOP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        stop_rel |=> (!ready_o && cnt_o == '0)) else $error("stop release ignored"); // R9

    AST_RESTART_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !mode_rd[3]) else $error("restart bit reads back"); // R4

endmodule

// File: tb/bt_interval_timer_tb_top.sv
// Bench for the interval timer: a table of mode writes walked by one loop,
// then directed tests for reset, counting, flag handling and stop release.
module bt_interval_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 4;
    localparam int TAP_A = 6;
    localparam int TAP_B = 3;
    localparam int TAP_C = 2;
    localparam int TAP_D = 1;
    localparam int NVEC  = 8;

    // Table: written code, expected stored code after the write.
    localparam logic [2:0] VEC_CODE [NVEC] = '{3'b000, 3'b011, 3'b010, 3'b101,
                                               3'b111, 3'b100, 3'b001, 3'b110};
    localparam logic [2:0] VEC_MODE [NVEC] = '{3'b000, 3'b011, 3'b011, 3'b101,
                                               3'b111, 3'b111, 3'b111, 3'b111};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_data = '0;
    logic [3:0]       mode_rd;
    logic [CNT_W-1:0] cnt_o;
    logic             irq_o;
    logic             irq_clr = 1'b0;
    logic             stop_rel = 1'b0;
    logic             ready_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bt_interval_timer #(
        .CNT_W (CNT_W), .TAP_A (TAP_A), .TAP_B (TAP_B), .TAP_C (TAP_C), .TAP_D (TAP_D)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mode_rd  (mode_rd),
        .cnt_o    (cnt_o),
        .irq_o    (irq_o),
        .irq_clr  (irq_clr),
        .stop_rel (stop_rel),
        .ready_o  (ready_o)
    );

    // Expected interval in clocks for a stored code.
    function automatic int interval_of(input logic [2:0] code);
        case (code)
            3'b000:  return 1 << (TAP_A + CNT_W);
            3'b011:  return 1 << (TAP_B + CNT_W);
            3'b101:  return 1 << (TAP_C + CNT_W);
            default: return 1 << (TAP_D + CNT_W);
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle write; returns at the negedge after the capturing edge.
    task automatic write_mode(input logic restart, input logic [2:0] code);
        wr_en   = 1'b1;
        wr_data = {restart, code};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        // Reset state R1.
        wait_clk(3);
        check("R1 mode", mode_rd, 4'b0011);
        check("R1 cnt", cnt_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 ready", ready_o, 0);
        rst_n = 1'b1;
        wait_clk(1);
        check("R1 ready after release", ready_o, 0);
        // Reset settling wait R8: code-011 interval after release.
        n = interval_of(3'b011);
        wait_clk(n - 2);
        check("R8 ready before wait end", ready_o, 0);
        check("R8 irq before wait end", irq_o, 0);
        wait_clk(1);
        check("R8 ready after wait", ready_o, 1);
        check("R2 irq at reset interval", irq_o, 1);

        // Table walk: restart with each code, time the next wrap (R2, R3, R4).
        for (int i = 0; i < NVEC; i++) begin
            write_mode(1'b1, VEC_CODE[i]);
            check("R3 mode readback", mode_rd, {1'b0, VEC_MODE[i]});
            check("R4 restart clears irq", irq_o, 0);
            n = interval_of(VEC_MODE[i]);
            wait_clk(n - 1);
            check("R4 full interval before wrap", irq_o, 0);
            wait_clk(1);
            check("R2 irq at interval", irq_o, 1);
            check("R2 cnt wrapped", cnt_o, 0);
        end

        // Counter pace R10: code 011, tick every 8 clocks.
        write_mode(1'b1, 3'b011);
        wait_clk(23);
        check("R10 cnt before third tick", cnt_o, 2);
        wait_clk(1);
        check("R10 cnt after third tick", cnt_o, 3);

        // Restart mid-interval R4.
        write_mode(1'b1, 3'b111);
        check("R4 cnt cleared", cnt_o, 0);
        check("R4 restart bit reads 0", mode_rd[3], 0);

        // Periodic request, hold and clear R5 R6 R7 (interval 32).
        wait_clk(32);
        check("R5 first wrap", irq_o, 1);
        wait_clk(10);
        check("R6 flag held", irq_o, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R7 clear pulse", irq_o, 0);
        wait_clk(20);
        check("R5 second wrap not early", irq_o, 0);
        wait_clk(1);
        check("R5 second wrap", irq_o, 1);

        // Clear colliding with a wrap R7: wrap lands at 96 from restart.
        wait_clk(31);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R7 wrap beats clear", irq_o, 1);

        // Mode write without restart keeps the flag R6.
        write_mode(1'b0, 3'b101);
        check("R6 plain write keeps flag", irq_o, 1);
        check("R3 plain write updates mode", mode_rd, 4'b0101);

        // Stop release R9: restart code 111, let flag rise, then release.
        write_mode(1'b1, 3'b111);
        wait_clk(40);
        check("R9 irq set before stop", irq_o, 1);
        check("R9 ready before stop", ready_o, 1);
        stop_rel = 1'b1;
        @(negedge clk);
        stop_rel = 1'b0;
        check("R9 ready low", ready_o, 0);
        check("R9 cnt cleared", cnt_o, 0);
        check("R9 irq kept", irq_o, 1);
        wait_clk(31);
        check("R9 ready before wait end", ready_o, 0);
        wait_clk(1);
        check("R9 ready after current interval", ready_o, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule